// File: doc/BRIEF.md
# Cartridge Authentication Handshake Responder

This block answers the console's start-up authentication challenge on behalf of a cartridge. After the console releases its reset line, it presents a two-phase pattern on two nibbles of the address bus. One phase is presented per rising edge of the slow cartridge clock. The responder recognises the pattern and keeps its open-drain-style handshake output high for a fixed three further edges. It then shifts out a fixed 22-bit response, one bit per cartridge clock edge. After that it parks the output high until the console resets it again. A status output reports that the whole response has been sent.

The block runs on the cartridge controller's own fast clock. The cartridge clock, the console reset and the address nibbles all arrive asynchronously. They pass through a multi-stage synchroniser, and rising edges of the cartridge clock are found by comparing successive synchronised samples. The address value that counts for an edge is the value held just before that edge.

Top module: `cart_auth_responder`

## Requirements
- R1: After the block's own reset (`rst_n` low on a `clk` edge), `auth_n` is 1 and `auth_done` is 0.
- R2: While `cart_rst_n` is low, the block stays idle: `auth_n` stays 1 and `auth_done` stays 0, whatever the address nibbles and `cart_clk` do.
- R3: The first challenge phase is `addr_lo`=4'hA with `addr_hi`=4'h5, taken from the value held just before a `cart_clk` rising edge. Any other value, including the second-phase value alone, starts nothing.
- R4: The second phase is `addr_lo`=4'h5 with `addr_hi`=4'hA, and it must be seen on the very next rising edge after the first phase. A repeated first phase keeps the block waiting for the second phase. Any other value sends it back to looking for the first phase.
- R5: On the three rising edges after the second-phase edge, `auth_n` stays 1.
- R6: On each of the next 22 rising edges, `auth_n` takes the next bit of 1000101000101000000111, leftmost first, and holds it until the following edge.
- R7: On the edge after the 22nd bit, `auth_n` returns to 1 and `auth_done` becomes 1. Both hold, and further challenges are ignored, until `cart_rst_n` goes low.
- R8: `cart_rst_n` going low at any point, including mid-response, returns `auth_n` to 1 and `auth_done` to 0. A full handshake can then run again.
- R9: Between rising edges of `cart_clk`, `auth_n` does not change.
- R10: `auth_n` reflects a `cart_clk` rising edge no later than SYNC_STAGES+2 `clk` cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Synchronous active-low local reset |
| cart_clk | input | 1 | Console cartridge clock, asynchronous |
| cart_rst_n | input | 1 | Console reset, active low, asynchronous |
| addr_lo | input | 4 | Address nibble A3..A0 |
| addr_hi | input | 4 | Address nibble A19..A16 |
| auth_n | output | 1 | Handshake response line, idles high |
| auth_done | output | 1 | High once the full response has been sent |

## Verification
The bench breaks the challenge in the three ways a faulty matcher could mishandle. A gap between the phases must not let the response start, as it would with a matcher that forgets nothing. A repeated first phase must still be accepted; a design that insists on strict alternation would drop it. The second phase alone must do nothing. It counts the delay edges exactly, because an off-by-one there shifts the whole 22-bit pattern, and it checks the line just before each edge to catch output changes between edges. It pulls the console reset mid-response to confirm the line snaps high and a second handshake succeeds, and it offers a fresh challenge after completion, which must be ignored.

// File: rtl/cah_pkg.sv
// Package: shared constants and state type for the handshake responder.
// Assumes the challenge nibbles and response pattern are fixed per product.
package cah_pkg;

    localparam logic [3:0]  P1_LO     = 4'hA;
    localparam logic [3:0]  P1_HI     = 4'h5;
    localparam logic [3:0]  P2_LO     = 4'h5;
    localparam logic [3:0]  P2_HI     = 4'hA;
    localparam int          RESP_LEN  = 22;
    localparam logic [21:0] RESP_BITS = 22'b1000101000101000000111;
    localparam int          GAP_EDGES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_ARMED,
        ST_DELAY,
        ST_SHIFT,
        ST_DONE
    } cah_state_e;

endpackage

// File: rtl/cah_sampler.sv
// Module: cah_sampler
// Brings the asynchronous cartridge clock, console reset and address nibbles
// into the local clock domain and flags rising edges of the cartridge clock.
// Assumes the address nibbles are stable for several local cycles around each
// cartridge clock edge, so bus-wide synchronisation is safe.
module cah_sampler #(
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cart_clk,
    input  logic          cart_rst_n,
    input  logic [AW-1:0] addr_lo,
    input  logic [AW-1:0] addr_hi,
    output logic          rise,
    output logic          cart_run,
    output logic [AW-1:0] lo_at_edge,
    output logic [AW-1:0] hi_at_edge
);

    localparam int BUS_W = 2 + 2 * AW;

    logic [BUS_W-1:0] raw_bus;
    logic [BUS_W-1:0] stage_q [SYNC_STAGES];
    logic [BUS_W-1:0] prev_q;

    assign raw_bus = {cart_clk, cart_rst_n, addr_hi, addr_lo};

    // Synchroniser chain: one register rank per stage.
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    // Purpose: capture the raw asynchronous bus.
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= raw_bus;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    // Purpose: pass the bus one rank further down the chain.
                    if (!rst_n) stage_q[gi] <= '0;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        // Purpose: keep the previous settled sample for edge detection.
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[SYNC_STAGES-1];
    end

    assign rise       = stage_q[SYNC_STAGES-1][BUS_W-1] & ~prev_q[BUS_W-1];
    assign cart_run   = stage_q[SYNC_STAGES-1][BUS_W-2];
    assign lo_at_edge = prev_q[AW-1:0];
    assign hi_at_edge = prev_q[2*AW-1:AW];

endmodule

// File: rtl/cah_shifter.sv
// Module: cah_shifter
// Holds the response pattern and presents it one bit at a time, most
// significant first. Assumes the controller loads before the first step.
module cah_shifter #(
    parameter int                LEN     = 22,
    parameter logic [LEN-1:0]    PATTERN = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic head,
    output logic exhausted
);

    localparam int CW = $clog2(LEN + 1);

    logic [LEN-1:0] sr_q;
    logic [CW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        // Purpose: load the pattern, or advance by one bit per step.
        if (!rst_n) begin
            sr_q  <= PATTERN;
            cnt_q <= '0;
        end else if (load) begin
            sr_q  <= PATTERN;
            cnt_q <= '0;
        end else if (step) begin
            sr_q  <= {sr_q[LEN-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign head      = sr_q[LEN-1];
    assign exhausted = (cnt_q == CW'(LEN));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LEN)); // R6

    AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted && !load) |=> exhausted); // R7

endmodule

// File: rtl/cah_ctrl.sv
// Module: cah_ctrl
// Handshake controller: hunts for the two-phase challenge, counts the gap
// edges, drives the response line from the shifter and parks in a done
// state. Assumes all inputs are already in the local clock domain.
module cah_ctrl
    import cah_pkg::*;
#(
    parameter int         AW     = 4,
    parameter int         GAP    = 3,
    parameter logic [AW-1:0] C1_LO = 4'hA,
    parameter logic [AW-1:0] C1_HI = 4'h5,
    parameter logic [AW-1:0] C2_LO = 4'h5,
    parameter logic [AW-1:0] C2_HI = 4'hA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          cart_run,
    input  logic [AW-1:0] lo_at_edge,
    input  logic [AW-1:0] hi_at_edge,
    input  logic          head,
    input  logic          exhausted,
    output logic          load,
    output logic          step,
    output logic          auth_n,
    output logic          auth_done
);

    localparam int GW = $clog2(GAP + 1);

    cah_state_e   state_q;
    logic [GW-1:0] gap_q;
    logic          is_p1;
    logic          is_p2;
    logic          gap_last;

    assign is_p1    = (lo_at_edge == C1_LO) && (hi_at_edge == C1_HI);
    assign is_p2    = (lo_at_edge == C2_LO) && (hi_at_edge == C2_HI);
    assign gap_last = (gap_q == GW'(GAP - 1));
    assign load     = (state_q == ST_DELAY) && rise && gap_last;
    assign step     = (state_q == ST_SHIFT) && rise && !exhausted;
    assign auth_done = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        // Purpose: advance the handshake on each cartridge clock edge.
        if (!rst_n || !cart_run) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
            auth_n  <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE:  state_q <= ST_HUNT;
                ST_HUNT:  if (rise && is_p1) state_q <= ST_ARMED;
                ST_ARMED: if (rise) begin
                    if (is_p2) begin
                        state_q <= ST_DELAY;
                        gap_q   <= '0;
                    end else if (!is_p1) begin
                        state_q <= ST_HUNT;
                    end
                end
                ST_DELAY: if (rise) begin
                    if (gap_last) state_q <= ST_SHIFT;
                    else          gap_q   <= gap_q + 1'b1;
                end
                ST_SHIFT: if (rise) begin
                    if (exhausted) begin
                        state_q <= ST_DONE;
                        auth_n  <= 1'b1;
                    end else begin
                        auth_n  <= head;
                    end
                end
                ST_DONE:  state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    AST_HIGH_OUTSIDE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |-> auth_n); // R5

    AST_CART_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cart_run |=> (auth_n && !auth_done)); // R8

    AST_QUIET_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && cart_run) |=> $stable(auth_n)); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_done && cart_run) |=> auth_done); // R7

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q < GW'(GAP)); // R5

endmodule

// File: rtl/cart_auth_responder.sv
// Module: cart_auth_responder (top)
// Answers the console's start-up challenge with a fixed serial response on
// auth_n. Assumes clk is many times faster than cart_clk so every cartridge
// clock phase spans several local cycles.
module cart_auth_responder
    import cah_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cart_clk,
    input  logic       cart_rst_n,
    input  logic [3:0] addr_lo,
    input  logic [3:0] addr_hi,
    output logic       auth_n,
    output logic       auth_done
);

    localparam int AW = 4;

    logic          rise;
    logic          cart_run;
    logic [AW-1:0] lo_at_edge;
    logic [AW-1:0] hi_at_edge;
    logic          load;
    logic          step;
    logic          head;
    logic          exhausted;

    cah_sampler #(
        .SYNC_STAGES (SYNC_STAGES),
        .AW          (AW)
    ) i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .cart_clk   (cart_clk),
        .cart_rst_n (cart_rst_n),
        .addr_lo    (addr_lo),
        .addr_hi    (addr_hi),
        .rise       (rise),
        .cart_run   (cart_run),
        .lo_at_edge (lo_at_edge),
        .hi_at_edge (hi_at_edge)
    );

    cah_ctrl #(
        .AW    (AW),
        .GAP   (GAP_EDGES),
        .C1_LO (P1_LO),
        .C1_HI (P1_HI),
        .C2_LO (P2_LO),
        .C2_HI (P2_HI)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .cart_run   (cart_run),
        .lo_at_edge (lo_at_edge),
        .hi_at_edge (hi_at_edge),
        .head       (head),
        .exhausted  (exhausted),
        .load       (load),
        .step       (step),
        .auth_n     (auth_n),
        .auth_done  (auth_done)
    );

    cah_shifter #(
        .LEN     (RESP_LEN),
        .PATTERN (RESP_BITS)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .head      (head),
        .exhausted (exhausted)
    );

    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step)); // R6

endmodule

// File: tb/test_cart_auth_responder.sv
`timescale 1ns/1ps
module test_cart_auth_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cart_clk = 1'b0;
    logic       cart_rst_n = 1'b0;
    logic [3:0] addr_lo = 4'h0;
    logic [3:0] addr_hi = 4'h0;
    logic       auth_n;
    logic       auth_done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cart_auth_responder i_cart_auth_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .cart_clk   (cart_clk),
        .cart_rst_n (cart_rst_n),
        .addr_lo    (addr_lo),
        .addr_hi    (addr_hi),
        .auth_n     (auth_n),
        .auth_done  (auth_done)
    );

    // Rows: {lo, hi, expected auth_n after edge, expected auth_done}.
    localparam int NROW = 30;
    localparam logic [9:0] VEC [NROW] = '{
        {4'hA,4'h5,1'b1,1'b0}, {4'h5,4'hA,1'b1,1'b0},
        {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b1,1'b0},
        {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b0,1'b0}, {4'h0,4'h0,1'b0,1'b0},
        {4'h0,4'h0,1'b0,1'b0}, {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b0,1'b0},
        {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b0,1'b0}, {4'h0,4'h0,1'b0,1'b0},
        {4'h0,4'h0,1'b0,1'b0}, {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b0,1'b0},
        {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b0,1'b0}, {4'h0,4'h0,1'b0,1'b0},
        {4'h0,4'h0,1'b0,1'b0}, {4'h0,4'h0,1'b0,1'b0}, {4'h0,4'h0,1'b0,1'b0},
        {4'h0,4'h0,1'b0,1'b0}, {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b1,1'b0},
        {4'h0,4'h0,1'b1,1'b0}, {4'h0,4'h0,1'b1,1'b1}, {4'hA,4'h5,1'b1,1'b1},
        {4'h5,4'hA,1'b1,1'b1}
    };

    function automatic string row_req(input int i);
        if (i < 2)       return "R3/R4";
        else if (i < 5)  return "R5";
        else if (i < 27) return "R6";
        else             return "R7";
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cartridge clock period: low half with new address, then high half.
    // pre = auth_n just before the rise, early = 5 cycles after, post = end.
    task automatic tick(input logic [3:0] lo, input logic [3:0] hi,
                        output logic pre, output logic early, output logic post);
        @(negedge clk);
        cart_clk = 1'b0;
        addr_lo  = lo;
        addr_hi  = hi;
        repeat (8) @(negedge clk);
        pre = auth_n;
        cart_clk = 1'b1;
        repeat (5) @(negedge clk);
        early = auth_n;
        repeat (3) @(negedge clk);
        post = auth_n;
    endtask

    task automatic quiet_ticks(input int n, input string req);
        logic p, e, q;
        for (int k = 0; k < n; k++) begin
            tick(4'h0, 4'h0, p, e, q);
            check(q == 1'b1, req, q, 1);
        end
    endtask

    task automatic cart_reset_pulse();
        @(negedge clk);
        cart_rst_n = 1'b0;
        repeat (6) @(negedge clk);
        cart_rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        logic p, e, q;
        logic prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(auth_n == 1'b1, "R1", auth_n, 1);
        check(auth_done == 1'b0, "R1", auth_done, 0);

        // R2: challenge ignored while console reset is low
        tick(4'hA, 4'h5, p, e, q);
        tick(4'h5, 4'hA, p, e, q);
        for (int k = 0; k < 26; k++) begin
            tick(4'h0, 4'h0, p, e, q);
            check(q == 1'b1 && auth_done == 1'b0, "R2", q, 1);
        end

        // Main table: R3..R7, R9, R10
        cart_rst_n = 1'b1;
        repeat (6) @(negedge clk);
        prev = 1'b1;
        for (int i = 0; i < NROW; i++) begin
            tick(VEC[i][9:6], VEC[i][5:2], p, e, q);
            check(q == VEC[i][1], row_req(i), q, VEC[i][1]);
            check(auth_done == VEC[i][0], row_req(i), auth_done, VEC[i][0]);
            check(p == prev, "R9", p, prev);
            check(e == VEC[i][1], "R10", e, VEC[i][1]);
            prev = VEC[i][1];
        end

        // R8: cart reset after done, then reset mid-response
        cart_reset_pulse();
        check(auth_n == 1'b1 && auth_done == 1'b0, "R8", auth_done, 0);
        tick(4'hA, 4'h5, p, e, q);
        tick(4'h5, 4'hA, p, e, q);
        for (int k = 0; k < 5; k++) tick(4'h0, 4'h0, p, e, q);
        check(q == 1'b0, "R8 second run bit2", q, 0);
        cart_reset_pulse();
        check(auth_n == 1'b1, "R8", auth_n, 1);
        check(auth_done == 1'b0, "R8", auth_done, 0);
        quiet_ticks(4, "R8");

        // R4: gap between phases must not start the response
        tick(4'hA, 4'h5, p, e, q);
        tick(4'h0, 4'h0, p, e, q);
        tick(4'h5, 4'hA, p, e, q);
        quiet_ticks(8, "R4");

        // R3: second phase alone starts nothing
        tick(4'h5, 4'hA, p, e, q);
        quiet_ticks(6, "R3");

        // R4: repeated first phase stays armed
        tick(4'hA, 4'h5, p, e, q);
        tick(4'hA, 4'h5, p, e, q);
        tick(4'h5, 4'hA, p, e, q);
        for (int k = 0; k < 3; k++) tick(4'h0, 4'h0, p, e, q);
        check(q == 1'b1, "R5", q, 1);
        tick(4'h0, 4'h0, p, e, q);
        check(q == 1'b1, "R4 bit1", q, 1);
        tick(4'h0, 4'h0, p, e, q);
        check(q == 1'b0, "R4 bit2", q, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule